// File: doc/BRIEF.md
# Indexed Register and Frame-Memory Window

This block is a small bus slave that sits between a host access port and two downstream targets: the device's internal register file and its frame memory. The host sees two locations. One is an index register. The other is a 4-byte data window. Each read or write of the window is sent to one of the two targets, and the top bit of the stored index chooses which. With that bit set, the remaining index bits form a byte address in frame memory. With it clear, the index plus the byte offset of the window location used forms a byte address in register space. Host addresses outside these two words have no effect and read as zero.

Each host request is accepted in a single cycle while the slave is idle. The request is then decoded into one of four targets: the index itself, a register access, a memory access, or nothing. The target is decided by the accepted request together with the stored index. Register and memory accesses are presented on their port with a valid/ready handshake. All fields are held until the port acknowledges. One cycle after that, the host receives exactly one response pulse carrying the read data, which is zero for writes.

The controller is a four-state machine:
- `ST_IDLE`: accepts a request. It moves to `ST_REG_WAIT` for a register target, to `ST_MEM_WAIT` for a memory target, and to `ST_REPLY` for an index access or a dropped access.
- `ST_REG_WAIT` and `ST_MEM_WAIT`: move to `ST_REPLY` on the port's ready.
- `ST_REPLY`: returns to `ST_IDLE` after one cycle.

Top module: `idx_window`

## Requirements
- R1: After reset, the following hold: the stored index is 0, `host_rdy` is 1, and `reg_vld`, `mem_vld` and `host_rsp_vld` are 0.
- R2: A write to the index word replaces only the bytes selected by size (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) starting at the lane `host_addr[1:0]`. A read of it returns the stored value, including bit 31, shifted down by that lane and masked to the size.
- R3: With index bit 31 set, a window access becomes a single memory request at byte address `index[30:0]`. The window's own byte offset is ignored. `mem_size` equals the host size. Data is little-endian and right-aligned, with byte 0 at the lowest address.
- R4: A memory request is issued only when `index[30:0]` ≤ MEM_BYTES − access bytes. Otherwise a write is dropped without any port activity and a read returns 0.
- R5: With index bit 31 clear, the target byte address is `index + host_addr[1:0]`, kept to AW bits. The request carries the word address (target ≫ 2), byte enables equal to the size mask shifted left by target[1:0] (bits beyond lane 3 dropped), and write data shifted into those lanes.
- R6: A register read returns the addressed field shifted down to bit 0, with bytes above the access size forced to 0.
- R7: A register-space target whose word equals the window's own word is dropped: no request is issued and a read returns 0.
- R8: While a downstream request waits, its valid and every field stay constant and `host_rdy` is 0. `host_rsp_vld` pulses exactly once, in the cycle after the acknowledge.
- R9: Host addresses other than the index and window words change nothing and read as 0.
- R10: Memory read data is masked to the access size; bytes above it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | Host request valid |
| host_rdy | output | 1 | Slave idle, request accepted when valid |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host byte address |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-aligned write data |
| host_rsp_vld | output | 1 | One-cycle response pulse |
| host_rdata | output | 32 | Right-aligned read data |
| reg_vld | output | 1 | Register request valid |
| reg_rdy | input | 1 | Register port acknowledge |
| reg_wr | output | 1 | Register write |
| reg_addr | output | AW-2 | Register word address |
| reg_be | output | 4 | Register byte enables |
| reg_wdata | output | 32 | Lane-aligned register write data |
| reg_rdata | input | 32 | Register word read data, valid with ready |
| mem_vld | output | 1 | Memory request valid |
| mem_rdy | input | 1 | Memory port acknowledge |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | log2(MEM_BYTES) | Memory byte address |
| mem_size | output | 2 | Memory access size code |
| mem_wdata | output | 32 | Right-aligned memory write data |
| mem_rdata | input | 32 | Little-endian memory read data, valid with ready |

## Verification
The assertions assume that the downstream ports return read data in the same cycle as their ready. They also assume the host issues a request only while `host_rdy` is high. The bench keeps the host to one outstanding request: it waits for each response before driving the next, and it drops `host_vld` right after the accepting edge. The register and memory models stall on fixed ready patterns. This exercises the wait states without ever presenting data outside an acknowledge. Every memory index the bench uses either fits the configured memory or is deliberately out of range.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;

    localparam int DATA_W = 32;
    localparam int NBYTES = DATA_W / 8;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_INDEX,
        TGT_REG,
        TGT_MEM
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REG_WAIT,
        ST_MEM_WAIT,
        ST_REPLY
    } state_e;

    // byte mask of an access of the given size code, lane 0 based
    function automatic logic [NBYTES-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 4'b0001;
            2'd1:    size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    endfunction

    // number of bytes moved by an access of the given size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/idx_window_decode.sv
module idx_window_decode
    import idx_window_pkg::*;
#(
    parameter int AW         = 12,
    parameter int MEM_BYTES  = 4096,
    parameter int INDEX_ADDR = 0,
    parameter int WIN_ADDR   = 4,
    localparam int MEM_AW    = $clog2(MEM_BYTES),
    localparam int WORD_AW   = AW - 2
) (
    input  logic [AW-1:0]      host_addr,
    input  logic [1:0]         host_size,
    input  logic [31:0]        index_q,
    output tgt_e               tgt,
    output logic [1:0]         lane,
    output logic [3:0]         be,
    output logic [WORD_AW-1:0] reg_word,
    output logic [MEM_AW-1:0]  mem_addr
);

    localparam logic [WORD_AW-1:0] IDX_WORD = WORD_AW'(INDEX_ADDR >> 2);
    localparam logic [WORD_AW-1:0] WIN_WORD = WORD_AW'(WIN_ADDR >> 2);

    logic [AW-1:0] reg_byte;
    logic [31:0]   mem_limit;
    logic          in_range;
    logic          hits_window;
    logic [6:0]    be_wide;
    logic          at_index;
    logic          at_window;

    always_comb begin
        reg_byte    = index_q[AW-1:0] + AW'(host_addr[1:0]);
        mem_limit   = 32'(MEM_BYTES) - 32'(size_bytes(host_size));
        in_range    = ({1'b0, index_q[30:0]} <= mem_limit);
        hits_window = (reg_byte[AW-1:2] == WIN_WORD);
        at_index    = (host_addr[AW-1:2] == IDX_WORD);
        at_window   = (host_addr[AW-1:2] == WIN_WORD);
        reg_word    = reg_byte[AW-1:2];
        mem_addr    = index_q[MEM_AW-1:0];
        tgt         = TGT_NONE;
        lane        = host_addr[1:0];
        if (at_index) begin
            tgt = TGT_INDEX;
        end else if (at_window) begin
            if (index_q[31]) begin
                lane = 2'd0;
                if (in_range) begin
                    tgt = TGT_MEM;
                end
            end else begin
                lane = reg_byte[1:0];
                if (!hits_window) begin
                    tgt = TGT_REG;
                end
            end
        end
        be_wide = {3'b000, size_mask(host_size)} << lane;
        be      = be_wide[3:0];
    end

endmodule

// File: rtl/idx_window_align.sv
module idx_window_align
    import idx_window_pkg::*;
(
    input  logic [DATA_W-1:0] wr_src,
    input  logic [DATA_W-1:0] rd_src,
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] wr_lane,
    output logic [DATA_W-1:0] rd_field
);

    logic [DATA_W-1:0] rd_shift;
    logic [NBYTES-1:0] keep;

    assign wr_lane  = wr_src << {lane, 3'b000};
    assign rd_shift = rd_src >> {lane, 3'b000};
    assign keep     = size_mask(size);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign rd_field[8*b +: 8] = keep[b] ? rd_shift[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/idx_window_ctrl.sv
module idx_window_ctrl
    import idx_window_pkg::*;
#(
    parameter int AW        = 12,
    parameter int MEM_BYTES = 4096,
    localparam int MEM_AW   = $clog2(MEM_BYTES),
    localparam int WORD_AW  = AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_vld,
    input  logic               host_wr,
    input  logic [1:0]         host_size,
    input  logic [31:0]        host_wdata,
    input  tgt_e               dec_tgt,
    input  logic [1:0]         dec_lane,
    input  logic [3:0]         dec_be,
    input  logic [WORD_AW-1:0] dec_word,
    input  logic [MEM_AW-1:0]  dec_maddr,
    output logic [31:0]        index_q,
    output logic               host_rdy,
    output logic               host_rsp_vld,
    output logic [31:0]        host_rdata,
    output logic               reg_vld,
    input  logic               reg_rdy,
    output logic               reg_wr,
    output logic [WORD_AW-1:0] reg_addr,
    output logic [3:0]         reg_be,
    output logic [31:0]        reg_wdata,
    input  logic [31:0]        reg_rdata,
    output logic               mem_vld,
    input  logic               mem_rdy,
    output logic               mem_wr,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);

    state_e             state_q;
    state_e             state_d;
    logic               wr_q;
    logic [1:0]         lane_q;
    logic [1:0]         size_q;
    logic [3:0]         be_q;
    logic [WORD_AW-1:0] word_q;
    logic [MEM_AW-1:0]  maddr_q;
    logic [31:0]        wdata_q;
    logic [31:0]        rsp_q;
    logic [31:0]        index_r;
    logic [31:0]        index_merge;
    logic               accept;
    logic               reg_ack;
    logic               mem_ack;

    logic [31:0]        al_wr_src;
    logic [31:0]        al_rd_src;
    logic [1:0]         al_lane;
    logic [1:0]         al_size;
    logic [31:0]        al_wr_lane;
    logic [31:0]        al_rd_field;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_vld) begin
                    case (dec_tgt)
                        TGT_REG: state_d = ST_REG_WAIT;
                        TGT_MEM: state_d = ST_MEM_WAIT;
                        default: state_d = ST_REPLY;
                    endcase
                end
            end
            ST_REG_WAIT: if (reg_rdy) state_d = ST_REPLY;
            ST_MEM_WAIT: if (mem_rdy) state_d = ST_REPLY;
            ST_REPLY:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs and strobes
    always_comb begin
        host_rdy     = 1'b0;
        host_rsp_vld = 1'b0;
        reg_vld      = 1'b0;
        mem_vld      = 1'b0;
        accept       = 1'b0;
        reg_ack      = 1'b0;
        mem_ack      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                host_rdy = 1'b1;
                accept   = host_vld;
            end
            ST_REG_WAIT: begin
                reg_vld = 1'b1;
                reg_ack = reg_rdy;
            end
            ST_MEM_WAIT: begin
                mem_vld = 1'b1;
                mem_ack = mem_rdy;
            end
            ST_REPLY: host_rsp_vld = 1'b1;
            default: ;
        endcase
    end

    // one shared aligner: request side while idle, held fields while waiting
    always_comb begin
        al_wr_src = (state_q == ST_IDLE) ? host_wdata : wdata_q;
        al_size   = (state_q == ST_IDLE) ? host_size  : size_q;
        if (state_q == ST_IDLE) begin
            al_lane = dec_lane;
        end else if (state_q == ST_MEM_WAIT) begin
            al_lane = 2'd0;
        end else begin
            al_lane = lane_q;
        end
        if (state_q == ST_REG_WAIT) begin
            al_rd_src = reg_rdata;
        end else if (state_q == ST_MEM_WAIT) begin
            al_rd_src = mem_rdata;
        end else begin
            al_rd_src = index_r;
        end
    end

    idx_window_align align_i (
        .wr_src   (al_wr_src),
        .rd_src   (al_rd_src),
        .lane     (al_lane),
        .size     (al_size),
        .wr_lane  (al_wr_lane),
        .rd_field (al_rd_field)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_idx_byte
        assign index_merge[8*b +: 8] = dec_be[b] ? al_wr_lane[8*b +: 8] : index_r[8*b +: 8];
    end

    // request capture, index register, response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            lane_q  <= '0;
            size_q  <= '0;
            be_q    <= '0;
            word_q  <= '0;
            maddr_q <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
            index_r <= '0;
        end else begin
            if (accept) begin
                wr_q    <= host_wr;
                lane_q  <= dec_lane;
                size_q  <= host_size;
                be_q    <= dec_be;
                word_q  <= dec_word;
                maddr_q <= dec_maddr;
                wdata_q <= host_wdata;
                if (dec_tgt == TGT_INDEX) begin
                    rsp_q <= host_wr ? 32'h0 : al_rd_field;
                    if (host_wr) begin
                        index_r <= index_merge;
                    end
                end else begin
                    rsp_q <= 32'h0;
                end
            end
            if (reg_ack || mem_ack) begin
                rsp_q <= wr_q ? 32'h0 : al_rd_field;
            end
        end
    end

    assign index_q    = index_r;
    assign host_rdata = rsp_q;
    assign reg_wr     = wr_q;
    assign reg_addr   = word_q;
    assign reg_be     = be_q;
    assign reg_wdata  = al_wr_lane;
    assign mem_wr     = wr_q;
    assign mem_addr   = maddr_q;
    assign mem_size   = size_q;
    assign mem_wdata  = wdata_q;

endmodule

// File: rtl/idx_window.sv
module idx_window
    import idx_window_pkg::*;
#(
    parameter int AW         = 12,
    parameter int MEM_BYTES  = 4096,
    parameter int INDEX_ADDR = 0,
    parameter int WIN_ADDR   = 4,
    localparam int MEM_AW    = $clog2(MEM_BYTES),
    localparam int WORD_AW   = AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_vld,
    output logic               host_rdy,
    input  logic               host_wr,
    input  logic [AW-1:0]      host_addr,
    input  logic [1:0]         host_size,
    input  logic [31:0]        host_wdata,
    output logic               host_rsp_vld,
    output logic [31:0]        host_rdata,
    output logic               reg_vld,
    input  logic               reg_rdy,
    output logic               reg_wr,
    output logic [WORD_AW-1:0] reg_addr,
    output logic [3:0]         reg_be,
    output logic [31:0]        reg_wdata,
    input  logic [31:0]        reg_rdata,
    output logic               mem_vld,
    input  logic               mem_rdy,
    output logic               mem_wr,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);

    tgt_e               dec_tgt;
    logic [1:0]         dec_lane;
    logic [3:0]         dec_be;
    logic [WORD_AW-1:0] dec_word;
    logic [MEM_AW-1:0]  dec_maddr;
    logic [31:0]        index_q;

    idx_window_decode #(
        .AW         (AW),
        .MEM_BYTES  (MEM_BYTES),
        .INDEX_ADDR (INDEX_ADDR),
        .WIN_ADDR   (WIN_ADDR)
    ) decode_i (
        .host_addr (host_addr),
        .host_size (host_size),
        .index_q   (index_q),
        .tgt       (dec_tgt),
        .lane      (dec_lane),
        .be        (dec_be),
        .reg_word  (dec_word),
        .mem_addr  (dec_maddr)
    );

    idx_window_ctrl #(
        .AW        (AW),
        .MEM_BYTES (MEM_BYTES)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_vld     (host_vld),
        .host_wr      (host_wr),
        .host_size    (host_size),
        .host_wdata   (host_wdata),
        .dec_tgt      (dec_tgt),
        .dec_lane     (dec_lane),
        .dec_be       (dec_be),
        .dec_word     (dec_word),
        .dec_maddr    (dec_maddr),
        .index_q      (index_q),
        .host_rdy     (host_rdy),
        .host_rsp_vld (host_rsp_vld),
        .host_rdata   (host_rdata),
        .reg_vld      (reg_vld),
        .reg_rdy      (reg_rdy),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_be       (reg_be),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .mem_vld      (mem_vld),
        .mem_rdy      (mem_rdy),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_size     (mem_size),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

endmodule

// File: rtl/idx_window_chk.sv
module idx_window_chk
    import idx_window_pkg::*;
#(
    parameter int AW        = 12,
    parameter int MEM_BYTES = 4096,
    parameter int WIN_ADDR  = 4,
    localparam int MEM_AW   = $clog2(MEM_BYTES),
    localparam int WORD_AW  = AW - 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_rdy,
    input logic               host_rsp_vld,
    input logic               reg_vld,
    input logic               reg_rdy,
    input logic               reg_wr,
    input logic [WORD_AW-1:0] reg_addr,
    input logic [3:0]         reg_be,
    input logic [31:0]        reg_wdata,
    input logic               mem_vld,
    input logic               mem_rdy,
    input logic               mem_wr,
    input logic [MEM_AW-1:0]  mem_addr,
    input logic [1:0]         mem_size,
    input logic [31:0]        mem_wdata
);

    localparam logic [WORD_AW-1:0] WIN_WORD = WORD_AW'(WIN_ADDR >> 2);

    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && !reg_rdy) |=> (reg_vld && $stable(reg_addr) && $stable(reg_be)
                                   && $stable(reg_wdata) && $stable(reg_wr)));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_vld && !mem_rdy) |=> (mem_vld && $stable(mem_addr) && $stable(mem_size)
                                   && $stable(mem_wdata) && $stable(mem_wr)));

    // R3
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_vld && mem_vld));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> (!reg_vld && !mem_vld && !host_rsp_vld));

    // R8
    reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_vld && reg_rdy) || (mem_vld && mem_rdy)) |=> host_rsp_vld);

    // R8
    single_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_vld |=> !host_rsp_vld);

    // R4
    mem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_vld |-> ((32'(mem_addr) + 32'(size_bytes(mem_size))) <= 32'(MEM_BYTES)));

    // R7
    no_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_vld |-> (reg_addr != WIN_WORD));

    // R5
    be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_vld |-> (reg_be != 4'b0000));

endmodule

bind idx_window idx_window_chk #(
    .AW        (AW),
    .MEM_BYTES (MEM_BYTES),
    .WIN_ADDR  (WIN_ADDR)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rdy     (host_rdy),
    .host_rsp_vld (host_rsp_vld),
    .reg_vld      (reg_vld),
    .reg_rdy      (reg_rdy),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_be       (reg_be),
    .reg_wdata    (reg_wdata),
    .mem_vld      (mem_vld),
    .mem_rdy      (mem_rdy),
    .mem_wr       (mem_wr),
    .mem_addr     (mem_addr),
    .mem_size     (mem_size),
    .mem_wdata    (mem_wdata)
);

// File: tb/idx_window_tb_top.sv
module idx_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_IDX = 12'h000;
    localparam logic [11:0] A_WIN = 12'h004;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_vld;
    logic        host_rdy;
    logic        host_wr;
    logic [11:0] host_addr;
    logic [1:0]  host_size;
    logic [31:0] host_wdata;
    logic        host_rsp_vld;
    logic [31:0] host_rdata;
    logic        reg_vld;
    logic        reg_rdy;
    logic        reg_wr;
    logic [9:0]  reg_addr;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_vld;
    logic        mem_rdy;
    logic        mem_wr;
    logic [11:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    idx_window dut_i (.*);

    // ---------------- downstream models ----------------
    logic [31:0] rf  [1024];
    logic [7:0]  mem [4096];
    logic [2:0]  tick;
    int          reg_hits;
    int          mem_hits;
    logic [9:0]  last_raddr;
    logic [3:0]  last_be;

    assign reg_rdy   = (tick[1:0] == 2'd3);
    assign mem_rdy   = tick[0];
    assign reg_rdata = rf[reg_addr];
    assign mem_rdata = {mem[mem_addr + 12'd3], mem[mem_addr + 12'd2],
                        mem[mem_addr + 12'd1], mem[mem_addr]};

    always @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            reg_hits <= 0;
            mem_hits <= 0;
        end else begin
            tick <= tick + 3'd1;
            if (reg_vld && reg_rdy) begin
                reg_hits   <= reg_hits + 1;
                last_raddr <= reg_addr;
                last_be    <= reg_be;
                if (reg_wr) begin
                    for (int b = 0; b < 4; b++)
                        if (reg_be[b]) rf[reg_addr][8*b +: 8] <= reg_wdata[8*b +: 8];
                end
            end
            if (mem_vld && mem_rdy) begin
                mem_hits <= mem_hits + 1;
                if (mem_wr) begin
                    for (int b = 0; b < 4; b++)
                        if (b < ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4))
                            mem[mem_addr + 12'(b)] <= mem_wdata[8*b +: 8];
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    int          vectors = 0;
    int          miscompares = 0;
    int          issued = 0;
    int          done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && host_rsp_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected response", host_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(host_rdata === e, t, host_rdata, e);
            end
            done++;
        end
    end

    // driver: one request, expected response pushed to the scoreboard
    task automatic xfer(input logic wr, input logic [11:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_vld   = 1'b1;
        host_wr    = wr;
        host_addr  = addr;
        host_size  = sz;
        host_wdata = wd;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issued++;
        @(negedge clk);
        host_vld = 1'b0;
        check(host_rdy == 1'b0, "R8 busy after accept", 32'(host_rdy), 32'h0);
        while (done != issued) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d,
                      input string tag);
        xfer(1'b1, a, s, d, 32'h0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] s, input logic [31:0] e,
                      input string tag);
        xfer(1'b0, a, s, 32'h0, e, tag);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done, issued);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    int h0;

    initial begin
        rst_n      = 1'b0;
        host_vld   = 1'b0;
        host_wr    = 1'b0;
        host_addr  = '0;
        host_size  = '0;
        host_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(host_rdy == 1'b1, "R1 host_rdy", 32'(host_rdy), 32'h1);
        check(!reg_vld && !mem_vld, "R1 port valids", {30'h0, reg_vld, mem_vld}, 32'h0);
        check(host_rsp_vld == 1'b0, "R1 rsp_vld", 32'(host_rsp_vld), 32'h0);
        rst_n = 1'b1;
        rd(A_IDX, 2'd2, 32'h0, "R1 index reset value");

        // R2 index write / read
        wr(A_IDX, 2'd2, 32'h0000_0100, "R2 index write");
        rd(A_IDX, 2'd2, 32'h0000_0100, "R2 index read");

        // R5 register write through window
        wr(A_WIN, 2'd2, 32'hAABB_CCDD, "R5 reg word write");
        check(last_raddr == 10'h040, "R5 reg word address", 32'(last_raddr), 32'h40);
        check(last_be == 4'hF, "R5 full byte enables", 32'(last_be), 32'hF);
        check(rf[10'h040] == 32'hAABB_CCDD, "R5 reg contents", rf[10'h040], 32'hAABB_CCDD);
        wr(A_WIN + 12'd2, 2'd0, 32'h0000_0055, "R5 reg byte write");
        check(last_be == 4'b0100, "R5 byte lane enable", 32'(last_be), 32'h4);
        rd(A_WIN, 2'd2, 32'hAA55_CCDD, "R5 other bytes kept");

        // R6 narrow register reads
        rd(A_WIN + 12'd1, 2'd1, 32'h0000_55CC, "R6 halfword lane1");
        rd(A_WIN + 12'd3, 2'd0, 32'h0000_00AA, "R6 byte lane3");
        rd(A_WIN + 12'd2, 2'd1, 32'h0000_AA55, "R6 halfword lane2");

        // R7 window pointing at itself
        wr(A_IDX, 2'd2, 32'h0000_0004, "R7 index to window");
        h0 = reg_hits;
        wr(A_WIN, 2'd2, 32'h1234_5678, "R7 self write");
        check(reg_hits == h0, "R7 no reg request on write", reg_hits, h0);
        rd(A_WIN, 2'd2, 32'h0, "R7 self read zero");
        wr(A_IDX, 2'd2, 32'h0000_0003, "R7 index 3");
        rd(A_WIN + 12'd1, 2'd0, 32'h0, "R7 offset reaches window");
        check(reg_hits == h0, "R7 no reg request on read", reg_hits, h0);

        // R3 memory access
        wr(A_IDX, 2'd2, 32'h8000_0010, "R3 index mem");
        h0 = mem_hits;
        wr(A_WIN, 2'd2, 32'h1122_3344, "R3 mem word write");
        check(mem_hits == h0 + 1, "R3 one mem request", mem_hits, h0 + 1);
        check(mem[12'h013] == 8'h11, "R3 little endian top byte", 32'(mem[12'h013]), 32'h11);
        rd(A_WIN, 2'd0, 32'h0000_0044, "R10 mem byte read");
        rd(A_WIN, 2'd1, 32'h0000_3344, "R10 mem half read");
        wr(A_WIN + 12'd3, 2'd0, 32'h0000_0077, "R3 window offset ignored");
        rd(A_WIN, 2'd2, 32'h1122_3377, "R3 mem word read");

        // R2 bit 31 visible, narrow index update
        rd(A_IDX, 2'd2, 32'h8000_0010, "R2 index with bit31");
        rd(A_IDX + 12'd3, 2'd0, 32'h0000_0080, "R2 index top byte");
        wr(A_IDX + 12'd1, 2'd0, 32'h0000_000F, "R2 narrow index write");
        rd(A_IDX, 2'd2, 32'h8000_0F10, "R2 narrow index merged");

        // R4 bounds
        wr(A_IDX, 2'd2, 32'h8000_0FFC, "R4 index last word");
        wr(A_WIN, 2'd2, 32'hCAFE_F00D, "R4 last word write");
        rd(A_WIN, 2'd2, 32'hCAFE_F00D, "R4 last word read");
        wr(A_IDX, 2'd2, 32'h8000_0FFD, "R4 index past end");
        h0 = mem_hits;
        wr(A_WIN, 2'd2, 32'hDEAD_BEEF, "R4 out of range write");
        check(mem_hits == h0, "R4 dropped write", mem_hits, h0);
        rd(A_WIN, 2'd2, 32'h0, "R4 out of range read");
        rd(A_WIN, 2'd0, 32'h0000_00F0, "R4 byte fits at FFD");
        wr(A_IDX, 2'd2, 32'h8000_0FFF, "R4 index last byte");
        rd(A_WIN, 2'd1, 32'h0, "R4 half past end");
        rd(A_WIN, 2'd0, 32'h0000_00CA, "R4 last byte");
        wr(A_IDX, 2'd2, 32'hFFFF_FFFF, "R4 index huge");
        h0 = mem_hits;
        wr(A_WIN, 2'd0, 32'h0000_0099, "R4 huge write");
        rd(A_WIN, 2'd0, 32'h0, "R4 huge read");
        check(mem_hits == h0, "R4 huge dropped", mem_hits, h0);

        // R9 unmapped host addresses
        h0 = reg_hits + mem_hits;
        wr(12'h040, 2'd2, 32'h5555_AAAA, "R9 unmapped write");
        rd(12'h040, 2'd2, 32'h0, "R9 unmapped read");
        check(reg_hits + mem_hits == h0, "R9 no downstream", reg_hits + mem_hits, h0);
        rd(A_IDX, 2'd2, 32'hFFFF_FFFF, "R9 index untouched");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule